// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Lockable Enable Policy

This block watches for software that has stopped running. A timeout counter runs while the watchdog is enabled. The counter advances once per prescaler period. If software lets the counter reach its terminal count, the block raises a system reset request for one clock cycle. Software restarts the counter by writing a two-byte key to the service port: 0x55 and then 0xAA.

The enable bit is not a plain read/write register. It follows one policy, chosen when the block is built:

- **Software-on:** the watchdog starts disabled. Software can turn it on once, and it then stays on.
- **Strapped:** a static option input decides the enable state when reset is applied. Software writes have no effect.
- **Default-on:** the watchdog starts enabled. The first software write decides for good between on and off.

A separate build switch removes the watchdog altogether. A reset that the watchdog itself causes returns the block to the same state as an external reset. This keeps the chosen policy in force after a software crash.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, the outputs take these values. `sys_rst_req` is 0. With `POLICY` = software-on: `en_status`=0 and `lock_status`=0. With strapped: `en_status`=`opt_enable` as sampled in reset, and `lock_status`=1. With default-on: `en_status`=1 and `lock_status`=0. With `PRESENT`=0: `en_status`=0 and `lock_status`=1.
- R2: Software-on policy, control write (`ctl_we`=1). A control write with `ctl_bit`=1 sets `en_status`=1 on the next cycle. A control write with `ctl_bit`=0 changes nothing. Once enabled, no control write can clear the enable until reset.
- R3: Strapped policy. Control writes and later changes of `opt_enable` leave `en_status` unchanged until the next reset.
- R4: Default-on policy. The first control write after reset sets `en_status` to `ctl_bit`. Every later control write is ignored until reset.
- R5: A service write (`svc_we`=1) of `svc_byte`=0x55, followed by a service write of 0xAA with no other service write in between, restarts the timeout. The restart happens at the clock edge that takes the 0xAA. Any other byte cancels a pending 0x55. A 0xAA without a pending 0x55 does nothing.
- R6: With `PRESENT`=0, `sys_rst_req` never rises and `en_status` reads 0.
- R7: While the watchdog is enabled, `sys_rst_req` is high for exactly one cycle. That cycle comes after `PRESCALE`*`TERM_COUNT` clock edges since the last restart, provided no service restart occurs in that window. A restart is a reset release, a service restart or a change of the enable.
- R8: `lock_status` reads 1 after any honoured control write under software-on or default-on. It stays 1 until reset.
- R9: The clock edge that ends the `sys_rst_req` cycle resets the counter, the service key state, the enable and the lock. It gives them the same values as R1.
- R10: While `en_status` is 0, the counter stays cleared and `sys_rst_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_bit | input | 1 | Enable value written with `ctl_we` |
| svc_we | input | 1 | Service write strobe |
| svc_byte | input | 8 | Service key byte |
| opt_enable | input | 1 | Static option, sampled in reset by the strapped policy |
| sys_rst_req | output | 1 | One-cycle system reset request |
| en_status | output | 1 | Current enable state |
| lock_status | output | 1 | 1 when control writes are ignored |

## Verification
All four build variants receive the same stimulus, side by side, so that each policy is compared with a behavioural model under identical writes.

Directed runs cover the following:
- an unserviced timeout, which sets the exact expiry cycle;
- a correct key pair, which moves that cycle later by a full period;
- a broken key (0x55, other byte, 0xAA), which must not move it;
- a sequence of 0, 1, 0 control writes, which separates sticky enable, first-write-wins and strapped behaviour.

Random service bytes biased toward the two key values then mix in the following:
- restarts and near-miss keys;
- rare control writes;
- resets with varying option values.

Together these show whether a watchdog-caused reset restores each policy correctly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    POL_SOFT_ON    = 2'd0,
    POL_STRAP      = 2'd1,
    POL_DEFAULT_ON = 2'd2
  } policy_e;

  localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
  localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;

  // Enable value applied by any reset (external or self-generated).
  function automatic logic reset_enable(policy_e pol, logic opt);
    case (pol)
      POL_STRAP:      return opt;
      POL_DEFAULT_ON: return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

  // Lock value applied by any reset.
  function automatic logic reset_lock(policy_e pol);
    return pol == POL_STRAP;
  endfunction

  // Key tracker: a service write re-arms only on the first key byte.
  function automatic logic arm_next(logic armed, logic we, logic [7:0] b);
    return we ? (b == SVC_KEY_FIRST) : armed;
  endfunction

  function automatic logic kick_now(logic armed, logic we, logic [7:0] b);
    return armed & we & (b == SVC_KEY_SECOND);
  endfunction

  // Number of enabled edges between a restart and the reset request.
  function automatic int unsigned expiry_edges(int unsigned pre, int unsigned term);
    return pre * term;
  endfunction

endpackage

// File: rtl/wdg_enable_ctrl.sv
module wdg_enable_ctrl
  import wdg_pkg::*;
#(
  parameter policy_e POLICY  = POL_DEFAULT_ON,
  parameter bit      PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_i,
  input  logic opt_i,
  input  logic ctl_we,
  input  logic ctl_bit,
  output logic en_o,
  output logic lock_o
);

  generate
    if (!PRESENT) begin : g_absent
      assign en_o   = 1'b0;
      assign lock_o = 1'b1;
    end else begin : g_present
      logic en_q, lock_q;
      logic wr_ok;

      assign wr_ok = ctl_we & ~lock_q & (POLICY != POL_STRAP);

      always_ff @(posedge clk) begin
        if (rst_i) begin
          en_q   <= reset_enable(POLICY, opt_i);
          lock_q <= reset_lock(POLICY);
        end else if (wr_ok) begin
          if (POLICY == POL_DEFAULT_ON) begin
            en_q   <= ctl_bit;
            lock_q <= 1'b1;
          end else if (ctl_bit) begin
            en_q   <= 1'b1;
            lock_q <= 1'b1;
          end
        end
      end

      assign en_o   = en_q;
      assign lock_o = lock_q;

      assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst_i)
        lock_q |=> lock_q);

      assert_locked_en_steady_R2: assert property (@(posedge clk) disable iff (rst_i)
        lock_q |=> $stable(en_q));

      if (POLICY == POL_STRAP) begin : g_chk_strap
        assert_strap_ignores_writes_R3: assert property (@(posedge clk) disable iff (rst_i)
          ctl_we |=> $stable(en_q));
      end

      if (POLICY == POL_DEFAULT_ON) begin : g_chk_def
        assert_first_write_decides_R4: assert property (@(posedge clk) disable iff (rst_i)
          (ctl_we && !lock_q) |=> (lock_q && (en_q == $past(ctl_bit))));
      end

      if (POLICY == POL_SOFT_ON) begin : g_chk_soft
        assert_soft_set_sticks_R2: assert property (@(posedge clk) disable iff (rst_i)
          (ctl_we && ctl_bit) |=> en_q);
      end
    end
  endgenerate

endmodule

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_i,
  input  logic       svc_we,
  input  logic [7:0] svc_byte,
  output logic       kick_o
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst_i) armed_q <= 1'b0;
    else       armed_q <= arm_next(armed_q, svc_we, svc_byte);
  end

  assign kick_o = kick_now(armed_q, svc_we, svc_byte);

  assert_kick_disarms_R5: assert property (@(posedge clk) disable iff (rst_i)
    kick_o |=> !armed_q);

endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout #(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned TERM_COUNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_i,
  input  logic en_i,
  input  logic kick_i,
  output logic bite_o
);

  localparam int PRE_W = (PRESCALE   > 1) ? $clog2(PRESCALE)   : 1;
  localparam int CNT_W = (TERM_COUNT > 1) ? $clog2(TERM_COUNT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TERM_COUNT - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bite_q;
  logic             tick, at_term, expire;

  assign tick    = (pre_q == PRE_LAST);
  assign at_term = (cnt_q == CNT_LAST);
  assign expire  = en_i & ~kick_i & tick & at_term;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= expire;
      if (!en_i || kick_i) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= at_term ? '0 : cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign bite_o = bite_q;

  assert_bite_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    bite_q |=> !bite_q);

  assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (rst_i)
    kick_i |=> (pre_q == '0 && cnt_q == '0));

  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst_i)
    !en_i |=> (!bite_q && cnt_q == '0));

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import wdg_pkg::*;
#(
  parameter policy_e     POLICY     = POL_DEFAULT_ON,
  parameter bit          PRESENT    = 1'b1,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned TERM_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic       ctl_bit,
  input  logic       svc_we,
  input  logic [7:0] svc_byte,
  input  logic       opt_enable,
  output logic       sys_rst_req,
  output logic       en_status,
  output logic       lock_status
);

  logic bite;
  logic rst_int;
  logic kick;
  logic en;
  logic lock;

  // A self-generated request resets the block exactly as the external reset does.
  assign rst_int = rst | bite;

  wdg_enable_ctrl #(.POLICY(POLICY), .PRESENT(PRESENT)) u_enable (
    .clk    (clk),
    .rst_i  (rst_int),
    .opt_i  (opt_enable),
    .ctl_we (ctl_we),
    .ctl_bit(ctl_bit),
    .en_o   (en),
    .lock_o (lock)
  );

  wdg_svc_seq u_svc (
    .clk     (clk),
    .rst_i   (rst_int),
    .svc_we  (svc_we),
    .svc_byte(svc_byte),
    .kick_o  (kick)
  );

  wdg_timeout #(.PRESCALE(PRESCALE), .TERM_COUNT(TERM_COUNT)) u_timeout (
    .clk   (clk),
    .rst   (rst),
    .rst_i (rst_int),
    .en_i  (en),
    .kick_i(kick),
    .bite_o(bite)
  );

  assign sys_rst_req = bite;
  assign en_status   = en;
  assign lock_status = lock;

  generate
    if (PRESENT) begin : g_chk_reapply
      assert_self_reset_reapplies_R9: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> ((en_status == reset_enable(POLICY, $past(opt_enable)))
                        && (lock_status == reset_lock(POLICY))));
    end else begin : g_chk_absent
      assert_absent_never_bites_R6: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_req);
    end
  endgenerate

endmodule

// File: tb/test_cop_watchdog.sv
module test_cop_watchdog;
  import wdg_pkg::*;

  localparam int unsigned P = 4;
  localparam int unsigned T = 8;
  localparam int unsigned N = P * T;

  logic       clk = 1'b0;
  logic       rst, ctl_we, ctl_bit, svc_we, opt_enable;
  logic [7:0] svc_byte;
  logic       req [4];
  logic       en  [4];
  logic       lk  [4];

  int total = 0;
  int bad   = 0;

  // bench model state, index 0 soft-on, 1 strapped, 2 default-on, 3 absent
  bit m_en[4], m_lock[4], m_arm[4], m_bite[4];
  int m_e[4];

  always #5 clk = ~clk;

  cop_watchdog #(.POLICY(POL_SOFT_ON), .PRESENT(1'b1), .PRESCALE(P), .TERM_COUNT(T)) i_cop_watchdog (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_bit(ctl_bit), .svc_we(svc_we),
    .svc_byte(svc_byte), .opt_enable(opt_enable),
    .sys_rst_req(req[0]), .en_status(en[0]), .lock_status(lk[0]));

  cop_watchdog #(.POLICY(POL_STRAP), .PRESENT(1'b1), .PRESCALE(P), .TERM_COUNT(T)) i_cop_watchdog_strap (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_bit(ctl_bit), .svc_we(svc_we),
    .svc_byte(svc_byte), .opt_enable(opt_enable),
    .sys_rst_req(req[1]), .en_status(en[1]), .lock_status(lk[1]));

  cop_watchdog #(.POLICY(POL_DEFAULT_ON), .PRESENT(1'b1), .PRESCALE(P), .TERM_COUNT(T)) i_cop_watchdog_defon (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_bit(ctl_bit), .svc_we(svc_we),
    .svc_byte(svc_byte), .opt_enable(opt_enable),
    .sys_rst_req(req[2]), .en_status(en[2]), .lock_status(lk[2]));

  cop_watchdog #(.POLICY(POL_DEFAULT_ON), .PRESENT(1'b0), .PRESCALE(P), .TERM_COUNT(T)) i_cop_watchdog_absent (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_bit(ctl_bit), .svc_we(svc_we),
    .svc_byte(svc_byte), .opt_enable(opt_enable),
    .sys_rst_req(req[3]), .en_status(en[3]), .lock_status(lk[3]));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit policy_en_at_reset(int i, bit opt);
    case (i)
      1:       return opt;
      2:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit policy_lock_at_reset(int i);
    return (i == 1) || (i == 3);
  endfunction

  task automatic model_edge(int i);
    bit kick;
    if (rst || m_bite[i]) begin
      m_bite[i] = 1'b0; m_arm[i] = 1'b0; m_e[i] = 0;
      m_en[i]   = policy_en_at_reset(i, opt_enable);
      m_lock[i] = policy_lock_at_reset(i);
    end else if (i != 3) begin
      kick = svc_we && (svc_byte == 8'hAA) && m_arm[i];
      if (svc_we) m_arm[i] = (svc_byte == 8'h55);
      if (!m_en[i] || kick) m_e[i] = 0;
      else begin
        m_e[i]++;
        if (m_e[i] == int'(N)) begin m_bite[i] = 1'b1; m_e[i] = 0; end
      end
      if (ctl_we && !m_lock[i]) begin
        if (i == 2) begin m_en[i] = ctl_bit; m_lock[i] = 1'b1; end
        else if (i == 0 && ctl_bit) begin m_en[i] = 1'b1; m_lock[i] = 1'b1; end
      end
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 4; i++) begin
      check((i == 3) ? "R6 req" : "R7 req", req[i], m_bite[i]);
      case (i)
        0: check("R2 en soft", en[i], m_en[i]);
        1: check("R3 en strap", en[i], m_en[i]);
        2: check("R4 en defon", en[i], m_en[i]);
        default: check("R6 en absent", en[i], m_en[i]);
      endcase
      check("R8 lock", lk[i], m_lock[i]);
    end
  endtask

  // one clock: model follows the edge, outputs sampled at the falling edge
  task automatic cycle();
    @(posedge clk);
    for (int i = 0; i < 4; i++) model_edge(i);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    ctl_we = 1'b0; svc_we = 1'b0; svc_byte = 8'h00; ctl_bit = 1'b0;
  endtask

  task automatic do_reset(bit opt);
    rst = 1'b1; opt_enable = opt; idle();
    cycle(); cycle();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1'b1);
    // R1: reset values per policy
    check("R1 soft en", en[0], 0);  check("R1 soft lock", lk[0], 0);
    check("R1 strap en", en[1], 1); check("R1 strap lock", lk[1], 1);
    check("R1 defon en", en[2], 1); check("R1 defon lock", lk[2], 0);
    check("R1 absent en", en[3], 0); check("R1 absent lock", lk[3], 1);
    check("R1 req", req[2], 0);

    // R7 / R10 / R9: unserviced expiry
    for (int k = 1; k <= int'(N) + 1; k++) begin
      cycle();
      if (k == int'(N) - 1) check("R7 early", req[2], 0);
      if (k == int'(N)) begin
        check("R7 expiry", req[2], 1);
        check("R3 strap expiry", req[1], 1);
        check("R10 disabled quiet", req[0], 0);
      end
      if (k == int'(N) + 1) begin
        check("R7 single cycle", req[2], 0);
        check("R9 en reapplied", en[2], 1);
        check("R9 lock reapplied", lk[2], 0);
      end
    end

    // R5: good key pair delays expiry by a full period from the 0xAA edge
    repeat (10) cycle();
    svc_we = 1'b1; svc_byte = 8'h55; cycle();
    svc_byte = 8'hAA; cycle();
    idle();
    for (int j = 1; j <= int'(N); j++) begin
      cycle();
      if (j == int'(N) - 1) check("R5 restart no early req", req[2], 0);
      if (j == int'(N)) check("R5 restart req", req[2], 1);
    end

    // R5: broken key does not restart
    do_reset(1'b0);
    svc_we = 1'b1; svc_byte = 8'h55; cycle();
    svc_byte = 8'h12; cycle();
    svc_byte = 8'hAA; cycle();
    idle();
    for (int j = 4; j <= int'(N); j++) begin
      cycle();
      if (j == int'(N)) check("R5 broken key", req[2], 1);
    end

    // R2 R3 R4 R6 R8: control writes 0,1,0
    do_reset(1'b0);
    check("R3 strap opt0", en[1], 0);
    ctl_we = 1'b1; ctl_bit = 1'b0; cycle(); idle();
    check("R2 soft write0", en[0], 0); check("R8 soft unlocked", lk[0], 0);
    check("R4 defon first0", en[2], 0); check("R8 defon locked", lk[2], 1);
    ctl_we = 1'b1; ctl_bit = 1'b1; cycle(); idle();
    check("R2 soft write1", en[0], 1); check("R8 soft locked", lk[0], 1);
    check("R4 defon ignores", en[2], 0);
    opt_enable = 1'b1;
    check("R3 strap ignores", en[1], 0);
    check("R6 absent", en[3], 0);
    ctl_we = 1'b1; ctl_bit = 1'b0; cycle(); idle();
    check("R2 soft sticky", en[0], 1);
    cycle();
    check("R3 strap opt change", en[1], 0);

    // random mix, checked every cycle against the model
    for (int n = 0; n < 6000; n++) begin
      int r;
      idle();
      rst = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 49) == 0) opt_enable = $urandom_range(0, 1);
      if ($urandom_range(0, 59) == 0) begin ctl_we = 1'b1; ctl_bit = $urandom_range(0, 1); end
      if ($urandom_range(0, 5) == 0) begin
        svc_we = 1'b1;
        r = $urandom_range(0, 9);
        svc_byte = (r < 4) ? 8'h55 : (r < 8) ? 8'hAA : 8'($urandom_range(0, 255));
      end
      cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule